// File: doc/BRIEF.md
# Split Result Register with Coherent Read Lock

This block stores a 10-bit conversion result that a processor reads as two byte-wide registers, a low byte and a high byte. A converter signals a finished conversion with a one-cycle valid strobe and the 10-bit result. Software reads the low byte first and the high byte second. Lock logic ensures that both bytes come from the same conversion.

A low-byte read freezes the stored result. Until the high byte is read, finished conversions do not reach the registers and their results are dropped. Every finished conversion still raises the completion interrupt flag, including one whose result was dropped. Software clears the flag by writing 1 to it.

The read data is registered and appears on the cycle after the read strobe. Address decoding and the converter are outside this block.

Top module: `split_result_lock`

## Requirements
- R1: After reset, the stored result is zero, the lock is clear, the interrupt flag is 0, and the read data output is 0.
- R2: A low-byte read (`rd_lo`=1) returns result bits 7:0 on `rd_data` one cycle after the strobe, and it sets the lock.
- R3: While the lock is set and no high-byte read occurs in the same cycle, a valid strobe leaves the stored result unchanged, so its data is lost.
- R4: A high-byte read (`rd_hi`=1 with `rd_lo`=0) clears the lock, so the next finished conversion is stored.
- R5: Every valid strobe sets the interrupt flag on the following cycle, whether its result is stored or dropped.
- R6: A high-byte read returns result bits 9:8 in `rd_data` bits 1:0, with bits 7:2 equal to zero, one cycle after the strobe.
- R7: A high-byte read while no lock is active leaves the lock clear, so a later conversion is still stored.
- R8: When a valid strobe and a high-byte read fall in the same cycle while locked, the read returns the old high byte and the new result is then stored.
- R9: When a valid strobe and a low-byte read fall in the same cycle while unlocked, the read returns the old low byte, the lock is set and the new result is dropped.
- R10: A write of 1 (`irq_clr`=1) clears the interrupt flag on the next cycle. A valid strobe in the same cycle wins, so the flag stays 1.
- R11: When `rd_lo` and `rd_hi` are both 1 in the same cycle, the block treats it as a low-byte read: it returns the low byte and sets the lock.
- R12: When no read strobe is present, `rd_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | One-cycle strobe marking a finished conversion |
| res_data | input | 10 | Conversion result, sampled with `res_valid` |
| rd_lo | input | 1 | Read strobe for the low-byte register |
| rd_hi | input | 1 | Read strobe for the high-byte register |
| irq_clr | input | 1 | Write of 1 to the interrupt flag, which clears it |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Completion interrupt flag |

## Verification
Both `rd_data` and `irq` pass through exactly one register, so each result is due on the first rising edge after its stimulus. The bench applies every stimulus for one cycle at a falling edge and removes it at the next falling edge. It samples the outputs at that same falling edge, half a cycle after the register has updated. The bench sweeps all 1024 result values through an unlocked read pair. It then runs the lock sequences and the same-cycle collisions. The stored result cannot be seen directly, so the bench checks it through later read pairs.

// File: rtl/srl_pkg.sv
package srl_pkg;
  parameter int unsigned RES_W_DEF  = 10;
  parameter int unsigned BYTE_W_DEF = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/srl_rd_decode.sv
module srl_rd_decode
  import srl_pkg::*;
(
  input  logic    rd_lo,
  input  logic    rd_hi,
  output rd_sel_e sel
);
  // Low-byte read dominates when both strobes are present (R11)
  always_comb begin
    if (rd_lo)      sel = SEL_LO;
    else if (rd_hi) sel = SEL_HI;
    else            sel = SEL_NONE;
  end
endmodule

// File: rtl/srl_lock_ctrl.sv
module srl_lock_ctrl
  import srl_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  rd_sel_e sel,
  input  logic    res_valid,
  output logic    lock,
  output logic    wr_en
);
  logic lock_q, lock_nxt;

  always_comb begin
    case (sel)
      SEL_LO:  lock_nxt = 1'b1;
      SEL_HI:  lock_nxt = 1'b0;
      default: lock_nxt = lock_q;
    endcase
  end

  // High read releases first, so a colliding completion is stored (R8).
  // Low read locks first, so a colliding completion is dropped (R9).
  assign wr_en = res_valid && (sel != SEL_LO) && (!lock_q || sel == SEL_HI);

  always_ff @(posedge clk) begin
    if (rst) lock_q <= 1'b0;
    else     lock_q <= lock_nxt;
  end

  assign lock = lock_q;

  assert_lo_sets_lock_R2: assert property (@(posedge clk) disable iff (rst)
    sel == SEL_LO |=> lock_q);
  assert_hi_clears_lock_R4: assert property (@(posedge clk) disable iff (rst)
    sel == SEL_HI |=> !lock_q);
  assert_hi_unlocked_stays_R7: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_HI && !lock_q) |=> !lock_q);
  assert_idle_holds_lock_R3: assert property (@(posedge clk) disable iff (rst)
    sel == SEL_NONE |=> $stable(lock_q));
endmodule

// File: rtl/srl_result_reg.sv
module srl_result_reg #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [RES_W-1:0] wr_data,
  output logic [RES_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wr_data;
  end

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/srl_read_mux.sv
module srl_read_mux
  import srl_pkg::*;
#(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  rd_sel_e           sel,
  input  logic [RES_W-1:0]  res_q,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int unsigned HI_W  = RES_W - BYTE_W;
  localparam int unsigned PAD_W = BYTE_W - HI_W;

  logic [BYTE_W-1:0] lo_byte, hi_byte;

  assign lo_byte = res_q[BYTE_W-1:0];

  generate
    if (PAD_W > 0) begin : g_pad
      assign hi_byte = {{PAD_W{1'b0}}, res_q[RES_W-1:BYTE_W]};
    end else begin : g_nopad
      assign hi_byte = res_q[RES_W-1:BYTE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (sel)
        SEL_LO:  rd_data <= lo_byte;
        SEL_HI:  rd_data <= hi_byte;
        default: rd_data <= rd_data;
      endcase
    end
  end

  assert_lo_read_R2: assert property (@(posedge clk) disable iff (rst)
    sel == SEL_LO |=> rd_data == $past(res_q[BYTE_W-1:0]));
  assert_hi_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    sel == SEL_HI |=> rd_data[BYTE_W-1:HI_W] == '0);
  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    sel == SEL_NONE |=> $stable(rd_data));
endmodule

// File: rtl/srl_irq_flag.sv
module srl_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assert_set_raises_R5: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);
  assert_clr_lowers_R10: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/split_result_lock.sv
module split_result_lock
  import srl_pkg::*;
#(
  parameter int unsigned RES_W  = RES_W_DEF,
  parameter int unsigned BYTE_W = BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic              irq_clr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq
);
  rd_sel_e          sel;
  logic             lock, wr_en;
  logic [RES_W-1:0] res_q;

  initial begin
    assert_widths_R6: assert (RES_W > BYTE_W && RES_W <= 2 * BYTE_W)
      else $error("result width must exceed one byte and fit in two");
  end

  srl_rd_decode u_dec (
    .rd_lo (rd_lo),
    .rd_hi (rd_hi),
    .sel   (sel)
  );

  srl_lock_ctrl u_lock (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .res_valid (res_valid),
    .lock      (lock),
    .wr_en     (wr_en)
  );

  srl_result_reg #(.RES_W(RES_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (res_data),
    .q       (res_q)
  );

  srl_read_mux #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_mux (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .res_q   (res_q),
    .rd_data (rd_data)
  );

  srl_irq_flag u_irq (
    .clk  (clk),
    .rst  (rst),
    .set  (res_valid),
    .clr  (irq_clr),
    .flag (irq)
  );

  assert_locked_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (lock && !rd_hi) |=> $stable(res_q));
  assert_hi_collide_store_R8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && rd_hi && !rd_lo) |=> res_q == $past(res_data));
  assert_lo_collide_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && rd_lo) |=> $stable(res_q));
  assert_unlocked_store_R4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !lock && !rd_lo) |=> res_q == $past(res_data));
  assert_both_reads_lock_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && rd_hi) |=> lock);
endmodule

// File: tb/split_result_lock_bench.sv
`timescale 1ns/1ps
module split_result_lock_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       res_valid, rd_lo, rd_hi, irq_clr;
  logic [9:0] res_data;
  logic [7:0] rd_data;
  logic       irq;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  split_result_lock u_split_result_lock (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .irq_clr(irq_clr),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One-cycle stimulus: set at a falling edge, clear at the next; outputs settle in between
  task automatic step(input logic v, input logic [9:0] d, input logic lo,
                      input logic hi, input logic clr);
    @(negedge clk);
    res_valid = v; res_data = d; rd_lo = lo; rd_hi = hi; irq_clr = clr;
    @(negedge clk);
    res_valid = 1'b0; rd_lo = 1'b0; rd_hi = 1'b0; irq_clr = 1'b0;
  endtask

  function automatic logic [7:0] lo_of(input logic [9:0] d);
    return 8'(d % 256);
  endfunction
  function automatic logic [7:0] hi_of(input logic [9:0] d);
    return 8'(d / 256);
  endfunction

  task automatic conv(input logic [9:0] d);  step(1'b1, d, 1'b0, 1'b0, 1'b0); endtask
  task automatic rlo;                        step(1'b0, '0, 1'b1, 1'b0, 1'b0); endtask
  task automatic rhi;                        step(1'b0, '0, 1'b0, 1'b1, 1'b0); endtask
  task automatic clri;                       step(1'b0, '0, 1'b0, 1'b0, 1'b1); endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    res_valid = 0; res_data = '0; rd_lo = 0; rd_hi = 0; irq_clr = 0; rst = 1;
    do_reset;
    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rlo; chk("R1 low byte", rd_data, 8'h00);
    rhi; chk("R1 high byte", rd_data, 8'h00);

    // Exhaustive sweep of values through an unlocked read pair: R2, R6, R5, R12
    for (int d = 0; d < 1024; d++) begin
      conv(10'(d));
      chk("R5 irq after conversion", {7'd0, irq}, 8'h01);
      rlo; chk("R2 low byte", rd_data, lo_of(10'(d)));
      rhi; chk("R6 high byte", rd_data, hi_of(10'(d)));
      if (d % 128 == 0) begin
        clri; chk("R10 irq cleared", {7'd0, irq}, 8'h00);
        chk("R12 hold", rd_data, hi_of(10'(d)));
      end
    end

    // Lock drops a conversion, irq still set: R3, R5, R4
    conv(10'h2A5); clri;
    rlo; chk("R2 lock low", rd_data, 8'hA5);
    conv(10'h15A);
    chk("R5 irq on dropped", {7'd0, irq}, 8'h01);
    rhi; chk("R3 high of old", rd_data, 8'h02);
    rlo; chk("R3 low unchanged", rd_data, 8'hA5);
    rhi; chk("R3 high unchanged", rd_data, 8'h02);
    conv(10'h15A);
    rlo; chk("R4 stored after unlock", rd_data, 8'h5A);
    rhi; chk("R4 high after unlock", rd_data, 8'h01);

    // High read while unlocked leaves lock clear: R7
    conv(10'h0F0);
    rhi; chk("R7 high unlocked", rd_data, 8'h00);
    conv(10'h30F);
    rlo; chk("R7 later stored", rd_data, 8'h0F);
    rhi; chk("R7 later high", rd_data, 8'h03);

    // Collision of high read and completion while locked: R8
    conv(10'h1C3);
    rlo; chk("R8 low", rd_data, 8'hC3);
    step(1'b1, 10'h23C, 1'b0, 1'b1, 1'b0);
    chk("R8 old high", rd_data, 8'h01);
    rlo; chk("R8 new low", rd_data, 8'h3C);
    rhi; chk("R8 new high", rd_data, 8'h02);

    // Collision of low read and completion while unlocked: R9
    conv(10'h081);
    step(1'b1, 10'h37E, 1'b1, 1'b0, 1'b0);
    chk("R9 old low", rd_data, 8'h81);
    rhi; chk("R9 old high", rd_data, 8'h00);
    rlo; chk("R9 new dropped", rd_data, 8'h81);
    rhi;

    // Clear versus set in same cycle, and clear with flag low: R10
    clri; chk("R10 clear", {7'd0, irq}, 8'h00);
    step(1'b1, 10'h111, 1'b0, 1'b0, 1'b1);
    chk("R10 set wins", {7'd0, irq}, 8'h01);
    clri; clri; chk("R10 clear stays low", {7'd0, irq}, 8'h00);

    // Both strobes at once act as a low read: R11
    step(1'b0, '0, 1'b1, 1'b1, 1'b0);
    chk("R11 returns low", rd_data, 8'h11);
    conv(10'h2EE);
    rhi; chk("R11 locked high", rd_data, 8'h01);
    rlo; chk("R11 low unchanged", rd_data, 8'h11);
    rhi;

    // Reset mid-lock clears everything: R1
    conv(10'h3FF); rlo; conv(10'h155);
    do_reset;
    chk("R1 rd_data after reset", rd_data, 8'h00);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    conv(10'h2C4);
    rlo; chk("R1 lock cleared", rd_data, 8'hC4);
    rhi; chk("R1 lock cleared high", rd_data, 8'h02);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule